// File: doc/BRIEF.md
# Board Parallel I/O Register Block

This block gives a CPU three byte-wide parallel ports on a simple bus that carries an address, a read strobe, a write strobe and write data. Port 0 drives two board LEDs and three reserved output lines. Port 1 reads an 8-contact DIP switch. Port 2 combines inputs and outputs. Its inputs are two memory presence-detect lines, a DSR status input and a sticky bus-timeout flag. Its outputs are a DTR control bit, an NMI mask and an active-low clear bit for the timeout flag.

A counter inside the block watches the CPU bus. When a request stays unacknowledged for 30 consecutive clocks, the counter drives the active-low timeout flag to 0. The flag stays at 0 until software writes the clear bit to 0 and then back to 1. The NMI mask bit gates the synchronized NMI input before it reaches the CPU. Read data is combinational: it is valid while `rd_i` is high and is zero otherwise. Writes take effect on the clock edge where `wr_i` is high.

Top module: `board_pio`

## Requirements
- R1: After reset, port 0 reads 0x00 and port 2 bits 3..0 read 1111. `led_o`, `rsvd0_o`, `dtr_o` and `nmi_o` are 0, and `rsvd1_o` is 1.
- R2: Port 0 is at address 0. Written bit 7 drives `led_o[1]` and written bit 6 drives `led_o[0]`, where 1 means lit. Written bits 2..0 drive `rsvd0_o`. Bits 5..3 always read 0. Every stored bit reads back as last written.
- R3: Port 1 is at address 1 and reads `~sw_on_i`. Contact k of the switch appears on bit k-1. A closed (ON) contact reads 0.
- R4: Port 2 is at address 2. Bit 7 reads `pd_i[1]` and bit 6 reads `pd_i[0]`. `mem_mb_o` decodes `pd_i` as follows: 00 gives 4, 01 (reserved) gives 0, 10 gives 16 and 11 gives 8.
- R5: Port 2 bit 5 is the timeout flag and is active low. It drops to 0 after a request (`bus_req_i`=1, `bus_ack_i`=0) has been pending at 30 consecutive clock edges. After 29 such edges it is still 1. Any edge where the request is not pending restarts the count.
- R6: Once the timeout flag is 0, it stays at 0 until cleared. While port 2 bit 1 (the clear bit, reset value 1) holds 0, the flag is held at 1, even if a request is pending.
- R7: Port 2 bit 2 is the NMI mask. While it is 1, `nmi_o` is 0. While it is 0, `nmi_o` follows `nmi_i` with a delay of two clocks.
- R8: Port 2 bit 3 is stored, and `dtr_o` is its inverse.
- R9: Port 2 bit 4 reads the inverse of `dsr_i`, two clocks after `dsr_i` changes.
- R10: Writes to port 1, to port 2 bits 7..4, and to address 3 have no effect. Address 3 reads 0x00. Port 2 bit 0 drives `rsvd1_o` and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Port address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when `rd_i` is low |
| bus_req_i | input | 1 | A CPU bus cycle is in progress |
| bus_ack_i | input | 1 | The CPU bus cycle completes |
| sw_on_i | input | 8 | DIP switch contacts, 1 = closed |
| pd_i | input | 2 | Memory presence-detect lines |
| dsr_i | input | 1 | DSR status, 1 = asserted |
| nmi_i | input | 1 | Raw NMI request |
| nmi_o | output | 1 | Gated NMI to the CPU |
| dtr_o | output | 1 | DTR control, 1 = asserted |
| led_o | output | 2 | LED drives, 1 = lit |
| rsvd0_o | output | 3 | Reserved outputs of port 0 |
| rsvd1_o | output | 1 | Reserved output of port 2 |
| mem_mb_o | output | 5 | Decoded memory size in MB, 0 = reserved |

## Verification
A wrong timeout count shows at the ports when port 2 bit 5 is read. The flag either falls one clock early or late at the 30th pending edge, or it fails to stay at 0 once the request ends. A broken clear sequence leaves bit 5 wrong on the first read after the write of 1. A mask or synchronizer fault shows at `nmi_o` or in port 2 bit 4 within two clocks of an input change. A fault in the stored bits shows at `led_o`, `dtr_o` or `rsvd*_o` right after the write edge, and in the readback.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_P0 = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_P1 = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_P2 = 2'd2;

  // presence-detect decode, result in MB, 0 = reserved code
  function automatic logic [4:0] pd_to_mb(input logic [1:0] pd);
    case (pd)
      2'b00:   return 5'd4;
      2'b10:   return 5'd16;
      2'b11:   return 5'd8;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else          st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pio_bus_timer.sv
module pio_bus_timer #(
  parameter int unsigned TMO_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  input  logic clr_ni,
  output logic flag_no
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          pend, hit, flag_nq;

  assign pend = req_i & ~ack_i;
  assign hit  = pend & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!pend)         cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // clear control dominates the set condition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_nq <= 1'b1;
    else if (!clr_ni) flag_nq <= 1'b1;
    else if (hit)    flag_nq <= 1'b0;
  end

  assign flag_no = flag_nq;
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [1:0]        led_q_o,
  output logic [2:0]        rsvd0_q_o,
  output logic              dtr_q_o,
  output logic              mask_q_o,
  output logic              clr_nq_o,
  output logic              rsvd1_q_o
);
  logic wr_p0, wr_p2;
  logic unused_wdata;

  assign wr_p0 = wr_i & (addr_i == ADDR_P0);
  assign wr_p2 = wr_i & (addr_i == ADDR_P2);
  assign unused_wdata = ^{wdata_i[5:3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q_o   <= '0;
      rsvd0_q_o <= '0;
    end else if (wr_p0) begin
      led_q_o   <= wdata_i[7:6];
      rsvd0_q_o <= wdata_i[2:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtr_q_o   <= 1'b1;
      mask_q_o  <= 1'b1;
      clr_nq_o  <= 1'b1;
      rsvd1_q_o <= 1'b1;
    end else if (wr_p2) begin
      dtr_q_o   <= wdata_i[3];
      mask_q_o  <= wdata_i[2];
      clr_nq_o  <= wdata_i[1];
      rsvd1_q_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/board_pio.sv
module board_pio
  import pio_pkg::*;
#(
  parameter int unsigned TMO_CYC     = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic              bus_req_i,
  input  logic              bus_ack_i,
  input  logic [PORT_W-1:0] sw_on_i,
  input  logic [1:0]        pd_i,
  input  logic              dsr_i,
  input  logic              nmi_i,
  output logic              nmi_o,
  output logic              dtr_o,
  output logic [1:0]        led_o,
  output logic [2:0]        rsvd0_o,
  output logic              rsvd1_o,
  output logic [4:0]        mem_mb_o
);
  logic [1:0] led_q;
  logic [2:0] rsvd0_q;
  logic       dtr_q, nmi_mask_q, clr_n_q, rsvd1_q;
  logic       tovf_n, dsr_s, nmi_s;

  pio_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .led_q_o   (led_q),
    .rsvd0_q_o (rsvd0_q),
    .dtr_q_o   (dtr_q),
    .mask_q_o  (nmi_mask_q),
    .clr_nq_o  (clr_n_q),
    .rsvd1_q_o (rsvd1_q)
  );

  pio_bus_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk_i, .rst_ni,
    .req_i   (bus_req_i),
    .ack_i   (bus_ack_i),
    .clr_ni  (clr_n_q),
    .flag_no (tovf_n)
  );

  pio_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({dsr_i, nmi_i}),
    .q_o ({dsr_s, nmi_s})
  );

  assign nmi_o    = nmi_s & ~nmi_mask_q;
  assign dtr_o    = ~dtr_q;
  assign led_o    = led_q;
  assign rsvd0_o  = rsvd0_q;
  assign rsvd1_o  = rsvd1_q;
  assign mem_mb_o = pd_to_mb(pd_i);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        ADDR_P0: rdata_o = {led_q, 3'b000, rsvd0_q};
        ADDR_P1: rdata_o = ~sw_on_i;
        ADDR_P2: rdata_o = {pd_i[1], pd_i[0], tovf_n, ~dsr_s,
                            dtr_q, nmi_mask_q, clr_n_q, rsvd1_q};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/board_pio_chk.sv
module board_pio_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic       bus_req_i,
  input logic       bus_ack_i,
  input logic       nmi_i,
  input logic       nmi_o,
  input logic [1:0] led_o,
  input logic       tovf_n,
  input logic       clr_n_q
);
  // flag can only fall after a pending request edge
  a_r5_fall_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tovf_n) |-> $past(bus_req_i && !bus_ack_i));

  a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tovf_n && clr_n_q) |=> !tovf_n);

  a_r6_clear_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_n_q |=> tovf_n);

  a_r7_nmi_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> $past(nmi_i, 2));

  a_r2_led_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 2'd0) |=> $stable(led_o));
endmodule

bind board_pio board_pio_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .bus_req_i (bus_req_i),
  .bus_ack_i (bus_ack_i),
  .nmi_i     (nmi_i),
  .nmi_o     (nmi_o),
  .led_o     (led_o),
  .tovf_n    (tovf_n),
  .clr_n_q   (clr_n_q)
);

// File: tb/board_pio_tb_top.sv
`timescale 1ns/1ps
module board_pio_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       bus_req_i = 1'b0, bus_ack_i = 1'b0;
  logic [7:0] sw_on_i = '0;
  logic [1:0] pd_i = 2'b10;
  logic       dsr_i = 1'b0, nmi_i = 1'b1;
  logic       nmi_o, dtr_o, rsvd1_o;
  logic [1:0] led_o;
  logic [2:0] rsvd0_o;
  logic [4:0] mem_mb_o;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] m_lo = 4'hF;  // model of port 2 bits 3..0
  logic       m_flag = 1'b1;

  always #2.5 clk_i = ~clk_i;

  board_pio dut_i (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // monitor: pops expected read data while rd_i is high
  always @(negedge clk_i) begin
    #2;
    if (rd_i && exp_q.size() > 0) chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
  end

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  function automatic logic [7:0] p2_exp();
    return {pd_i, m_flag, ~dsr_i, m_lo};
  endfunction

  task automatic pend(int n);
    @(negedge clk_i); bus_req_i = 1'b1;
    repeat (n) @(negedge clk_i);
    bus_req_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #1;
    // R1 reset state
    chk("R1 led", led_o, 0); chk("R1 dtr", dtr_o, 0);
    chk("R1 nmi masked", nmi_o, 0); chk("R1 rsvd", {rsvd0_o, rsvd1_o}, 4'b0001);
    rd(0, 8'h00, "R1 port0");
    rd(2, p2_exp(), "R1 port2");
    // R2
    wr(0, 8'hFF); #1;
    chk("R2 led", led_o, 2'b11); chk("R2 rsvd0", rsvd0_o, 3'b111);
    rd(0, 8'hC7, "R2 readback");
    wr(0, 8'h80); #1;
    chk("R2 led7", led_o, 2'b10); chk("R2 rsvd0 clr", rsvd0_o, 0);
    rd(0, 8'h80, "R2 readback2");
    // R3
    sw_on_i = 8'h01; rd(1, 8'hFE, "R3 contact1");
    sw_on_i = 8'hA5; rd(1, 8'h5A, "R3 pattern");
    // R10
    wr(1, 8'h00); rd(1, 8'h5A, "R10 port1 write ignored");
    wr(3, 8'hFF); rd(3, 8'h00, "R10 addr3");
    rd(0, 8'h80, "R10 addr3 no alias");
    // R4
    for (int i = 0; i < 4; i++) begin
      logic [4:0] mb;
      pd_i = 2'(i);
      mb = (i == 0) ? 5'd4 : (i == 1) ? 5'd0 : (i == 2) ? 5'd16 : 5'd8;
      #1 chk("R4 mem_mb", mem_mb_o, mb);
      rd(2, p2_exp(), "R4 pd bits");
    end
    // R8
    wr(2, 8'h07); m_lo = 4'h7; #1;
    chk("R8 dtr asserted", dtr_o, 1);
    rd(2, p2_exp(), "R8 readback");
    wr(2, 8'hFF); m_lo = 4'hF; #1;
    chk("R8 dtr off", dtr_o, 0);
    rd(2, p2_exp(), "R10 port2 upper ignored");
    wr(2, 8'h0E); m_lo = 4'hE; #1;
    chk("R10 rsvd1", rsvd1_o, 0);
    wr(2, 8'h0F); m_lo = 4'hF;
    // R9
    dsr_i = 1'b1; repeat (3) @(negedge clk_i);
    rd(2, p2_exp(), "R9 dsr");
    // R7
    nmi_i = 1'b1; repeat (3) @(negedge clk_i); #1;
    chk("R7 masked", nmi_o, 0);
    wr(2, 8'h0B); m_lo = 4'hB; #1;
    chk("R7 unmasked", nmi_o, 1);
    @(negedge clk_i); nmi_i = 1'b0;
    @(negedge clk_i); #1 chk("R7 1clk hold", nmi_o, 1);
    @(negedge clk_i); #1 chk("R7 2clk drop", nmi_o, 0);
    // R5
    pend(29); rd(2, p2_exp(), "R5 29 edges");
    pend(20);
    @(negedge clk_i); bus_req_i = 1'b1; bus_ack_i = 1'b1;
    @(negedge clk_i); bus_ack_i = 1'b0; bus_req_i = 1'b0;
    pend(20); rd(2, p2_exp(), "R5 ack restarts");
    pend(30); m_flag = 1'b0;
    repeat (10) @(negedge clk_i);
    rd(2, p2_exp(), "R6 sticky");
    // R6 clear sequence
    wr(2, 8'h09); m_lo = 4'h9; m_flag = 1'b1;
    rd(2, p2_exp(), "R6 held while clr low");
    pend(40); rd(2, p2_exp(), "R6 clr low blocks");
    wr(2, 8'h0B); m_lo = 4'hB;
    rd(2, p2_exp(), "R6 cleared");
    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule